// File: doc/BRIEF.md
# Packed Saturating Integer ALU

This block is a 64-bit packed-integer arithmetic unit. Each operand is treated as a vector of equal lanes, whose width is chosen per operation by a size selector: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane is computed on its own, and no carry or borrow ever crosses from one lane into its neighbour.

The unit offers five operations. Two add lanes and wrap or clamp them without sign. A third adds lanes as two's-complement numbers and clamps them to the signed range. A signed greater-than compare turns each lane into an all-ones or all-zeros mask. A narrowing pack turns the signed 16-bit words of both operands into unsigned-saturated bytes. The result is combinational from the inputs. A registered strobe marks, one clock later, that an operation was issued, so a pipeline that captures the result on the issuing edge can tag it.

Top module: `simd_sat_alu`

## Requirements
- R1: `size_i` selects the lane width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Lane i occupies result bits [i*W+W-1 : i*W], and each lane depends only on the same bits of `a_i` and `b_i`.
- R2: `op_i` = 0 adds each lane modulo 2^W. A carry out of a lane is dropped and never reaches the next lane.
- R3: `op_i` = 1 adds each lane as unsigned. When the true sum exceeds 2^W-1, the lane gives all ones (byte FFh + 01h = FFh). Otherwise it gives the plain sum (12h + 87h = 99h).
- R4: `op_i` = 2 adds each lane as two's complement. Positive overflow gives 2^(W-1)-1 and negative overflow gives -2^(W-1).
- R5: `op_i` = 3 compares lanes as signed numbers. A lane becomes all ones when a > b and all zeros otherwise. Doubleword FFFFFFFFh > 00010002h is false.
- R6: `op_i` = 4 treats A and B as four signed 16-bit words each, whatever `size_i` holds. A's words k=0..3 go to result byte k and B's words go to byte 4+k. A word above 00FFh gives FFh, a negative word gives 00h, and any other word gives its low byte.
- R7: `op_i` values 5, 6 and 7 give a zero result.
- R8: `valid_o` equals `valid_i` delayed by one rising clock edge, and it is 0 while `rst_ni` is low. `result_o` follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation issued this cycle |
| op_i | input | 3 | Operation code (R2 to R7) |
| size_i | input | 2 | Lane width select (R1) |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| result_o | output | 64 | Combinational packed result |
| valid_o | output | 1 | Registered issue strobe |

## Verification
Every arithmetic, compare and pack result is due in the same cycle as its operands. The bench therefore drives inputs just after a falling edge and samples `result_o` one time unit later, well before the next rising edge. `valid_o` is due after exactly one rising edge, so the bench raises `valid_i` on a falling edge and reads the strobe at the following falling edge. Lane results are compared against a per-lane reference model and against hand-computed values at the saturation boundaries.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD_WRAP  = 3'd0,
    OP_ADD_USAT  = 3'd1,
    OP_ADD_SSAT  = 3'd2,
    OP_CMP_GT    = 3'd3,
    OP_PACK_USAT = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_QWORD = 2'd3
  } lane_size_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] wrap_o,
  output logic [LANE_W-1:0] usat_o,
  output logic [LANE_W-1:0] ssat_o,
  output logic [LANE_W-1:0] gt_o
);
  localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

  logic [LANE_W:0] sum_ext;
  logic            s_ovf;

  assign sum_ext = {1'b0, a_i} + {1'b0, b_i};
  assign wrap_o  = sum_ext[LANE_W-1:0];
  assign usat_o  = sum_ext[LANE_W] ? {LANE_W{1'b1}} : sum_ext[LANE_W-1:0];

  // signed overflow: like-signed operands yield an opposite-signed sum
  assign s_ovf   = (a_i[LANE_W-1] == b_i[LANE_W-1]) &&
                   (sum_ext[LANE_W-1] != a_i[LANE_W-1]);
  assign ssat_o  = s_ovf ? (a_i[LANE_W-1] ? SMIN : SMAX) : sum_ext[LANE_W-1:0];
  assign gt_o    = ($signed(a_i) > $signed(b_i)) ? {LANE_W{1'b1}} : '0;
endmodule

// File: rtl/simd_slice.sv
module simd_slice #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] wrap_o,
  output logic [DATA_W-1:0] usat_o,
  output logic [DATA_W-1:0] ssat_o,
  output logic [DATA_W-1:0] gt_o
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    simd_lane #(.LANE_W(LANE_W)) u_lane (
      .a_i    (a_i[l*LANE_W +: LANE_W]),
      .b_i    (b_i[l*LANE_W +: LANE_W]),
      .wrap_o (wrap_o[l*LANE_W +: LANE_W]),
      .usat_o (usat_o[l*LANE_W +: LANE_W]),
      .ssat_o (ssat_o[l*LANE_W +: LANE_W]),
      .gt_o   (gt_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/simd_pack.sv
module simd_pack #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] pack_o
);
  localparam int NUM_WORDS = DATA_W / 16;

  function automatic logic [7:0] clamp_u8(input logic [15:0] w);
    if (w[15])          return 8'h00;
    else if (|w[14:8])  return 8'hFF;
    else                return w[7:0];
  endfunction

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    assign pack_o[k*8 +: 8]             = clamp_u8(a_i[k*16 +: 16]);
    assign pack_o[(NUM_WORDS+k)*8 +: 8] = clamp_u8(b_i[k*16 +: 16]);
  end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int BASE_LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  localparam int NUM_SIZES = $clog2(DATA_W / BASE_LANE_W) + 1;

  logic [DATA_W-1:0] wrap_s [NUM_SIZES];
  logic [DATA_W-1:0] usat_s [NUM_SIZES];
  logic [DATA_W-1:0] ssat_s [NUM_SIZES];
  logic [DATA_W-1:0] gt_s   [NUM_SIZES];
  logic [DATA_W-1:0] pack_r;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    simd_slice #(.DATA_W(DATA_W), .LANE_W(BASE_LANE_W << s)) u_slice (
      .a_i    (a_i),
      .b_i    (b_i),
      .wrap_o (wrap_s[s]),
      .usat_o (usat_s[s]),
      .ssat_o (ssat_s[s]),
      .gt_o   (gt_s[s])
    );
  end

  simd_pack #(.DATA_W(DATA_W)) u_pack (
    .a_i    (a_i),
    .b_i    (b_i),
    .pack_o (pack_r)
  );

  always_comb begin
    case (alu_op_e'(op_i))
      OP_ADD_WRAP:  result_o = wrap_s[size_i];
      OP_ADD_USAT:  result_o = usat_s[size_i];
      OP_ADD_SSAT:  result_o = ssat_s[size_i];
      OP_CMP_GT:    result_o = gt_s[size_i];
      OP_PACK_USAT: result_o = pack_r;
      default:      result_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assert_valid_pipe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_usat_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ADD_USAT && size_i == SZ_BYTE)
      |-> (result_o[7:0] >= a_i[7:0]));
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ADD_SSAT && size_i == SZ_WORD && a_i[15] == b_i[15])
      |-> (result_o[15] == a_i[15]));
  assert_cmp_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CMP_GT && size_i == SZ_BYTE)
      |-> (result_o[7:0] == 8'h00 || result_o[7:0] == 8'hFF));
  assert_pack_neg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_PACK_USAT && a_i[15]) |-> (result_o[7:0] == 8'h00));
  assert_unused_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'd4) |-> (result_o == '0));
endmodule

// File: tb/simd_sat_alu_tb.sv
module simd_sat_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] result_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  simd_sat_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .size_i(size_i), .a_i(a_i), .b_i(b_i), .result_o(result_o), .valid_o(valid_o)
  );

  function automatic logic [63:0] ref_model(input logic [2:0] op, input logic [1:0] sz,
                                            input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    int w = 8 << sz;
    logic [64:0] m = (65'd1 << w) - 65'd1;
    if (op == 3'd4) begin
      for (int k = 0; k < 8; k++) begin
        logic [15:0] wd = (k < 4) ? a[k*16 +: 16] : b[(k-4)*16 +: 16];
        logic [7:0] bt;
        if ($signed(wd) < 0) bt = 8'h00;
        else if (wd > 16'h00FF) bt = 8'hFF;
        else bt = wd[7:0];
        r[k*8 +: 8] = bt;
      end
      return r;
    end
    if (op > 3'd4) return '0;
    for (int i = 0; i < 64 / w; i++) begin
      logic [64:0] la = {1'b0, a >> (i*w)} & m;
      logic [64:0] lb = {1'b0, b >> (i*w)} & m;
      logic signed [66:0] sa = $signed({2'b00, la});
      logic signed [66:0] sb = $signed({2'b00, lb});
      logic signed [66:0] smax = $signed((67'd1 << (w-1)) - 67'd1);
      logic signed [66:0] smin = -$signed(67'd1 << (w-1));
      logic signed [66:0] ss;
      logic [64:0] lane;
      if (la[w-1]) sa = sa - $signed(67'd1 << w);
      if (lb[w-1]) sb = sb - $signed(67'd1 << w);
      case (op)
        3'd0: lane = (la + lb) & m;
        3'd1: lane = ((la + lb) > m) ? m : (la + lb);
        3'd2: begin
          ss = sa + sb;
          if (ss > smax) ss = smax;
          if (ss < smin) ss = smin;
          lane = ss[64:0] & m;
        end
        default: lane = (sa > sb) ? m : '0;
      endcase
      r = r | (lane[63:0] << (i*w));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive off the active edge, sample the combinational result one unit later
  task automatic run_op(input string tag, input logic [2:0] op, input logic [1:0] sz,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] exp);
    @(negedge clk_i);
    op_i = op; size_i = sz; a_i = a; b_i = b;
    #1;
    check(tag, result_o, exp);
    check({tag, " model"}, result_o, ref_model(op, sz, a, b));
  endtask

  task automatic t_reset;
    #2;
    check("R8 reset valid_o", {63'd0, valid_o}, 64'd0);
    valid_i = 1'b1;
    repeat (2) @(posedge clk_i);
    #1;
    check("R8 valid_o held in reset", {63'd0, valid_o}, 64'd0);
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic t_wrap_layout;
    run_op("R2 byte wrap no cross", 3'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 64'h0000_0000_0000_0000);
    run_op("R1 word lanes", 3'd0, 2'd1, 64'h00FF_00FF_FFFF_0001, 64'h0001_0001_0001_0001, 64'h0100_0100_0000_0002);
    run_op("R1 dword lanes", 3'd0, 2'd2, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000);
    run_op("R1 qword lane", 3'd0, 2'd3, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0000);
  endtask

  task automatic t_usat;
    run_op("R3 byte usat", 3'd1, 2'd0, 64'hFF00_1234_5678_FFFF, 64'h0102_8765_4321_0100, 64'hFF02_9999_9999_FFFF);
    run_op("R3 word usat", 3'd1, 2'd1, 64'hFFF0_0001_8000_1234, 64'h0020_0002_8000_0000, 64'hFFFF_0003_FFFF_1234);
    run_op("R3 qword usat", 3'd1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0005, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_ssat;
    run_op("R4 byte ssat", 3'd2, 2'd0, 64'h7F80_7F80_0102_FF10, 64'h01FF_7F80_0304_FF20, 64'h7F80_7F80_0406_FE30);
    run_op("R4 word ssat", 3'd2, 2'd1, 64'h7FFF_8000_4000_C000, 64'h0001_FFFF_4000_C000, 64'h7FFF_8000_7FFF_8000);
    run_op("R4 dword ssat", 3'd2, 2'd2, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_8000_0000, 64'h7FFF_FFFF_8000_0000);
  endtask

  task automatic t_cmp;
    run_op("R5 dword signed gt", 3'd3, 2'd2, 64'hFFFF_FFFF_1234_5678, 64'h0001_0002_8765_4321, 64'h0000_0000_FFFF_FFFF);
    run_op("R5 byte masks", 3'd3, 2'd0, 64'h0180_7F00_0505_FF01, 64'h00FF_8001_0506_00FF, 64'hFF00_FF00_0000_00FF);
    run_op("R5 qword gt", 3'd3, 2'd3, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_pack;
    run_op("R6 pack clamp", 3'd4, 2'd0, 64'h0042_FFFF_0100_00FF, 64'h8000_7FFF_0000_0012, 64'h00FF_0012_4200_FFFF);
    run_op("R6 pack ignores size", 3'd4, 2'd3, 64'h0042_FFFF_0100_00FF, 64'h8000_7FFF_0000_0012, 64'h00FF_0012_4200_FFFF);
  endtask

  task automatic t_unused;
    for (int op = 5; op < 8; op++)
      run_op("R7 unused op zero", 3'(op), 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'd0);
  endtask

  task automatic t_sweep;
    logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 60; n++) begin
      logic [63:0] a, b;
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      a = x;
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      b = x;
      @(negedge clk_i);
      op_i = 3'(n % 5); size_i = 2'(n / 5); a_i = a; b_i = b;
      #1;
      check("R1 sweep vs per-lane model", result_o, ref_model(op_i, size_i, a, b));
    end
  endtask

  task automatic t_valid;
    @(negedge clk_i);
    valid_i = 1'b1;
    @(negedge clk_i);
    check("R8 valid_o one edge later", {63'd0, valid_o}, 64'd1);
    valid_i = 1'b0;
    @(negedge clk_i);
    check("R8 valid_o drops", {63'd0, valid_o}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wrap_layout();
    t_usat();
    t_ssat();
    t_cmp();
    t_pack();
    t_unused();
    t_sweep();
    t_valid();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule